// File: doc/BRIEF.md
# Pixel-Clock Synthesizer Coefficient Search

This block picks the three divider settings for a programmable clock synthesizer. A start pulse gives it a requested output frequency and a reference frequency, both in kHz. It then steps through every legal combination of feedback multiplier M, reference divider N and post-divider shift P. The outer loop is N, the middle loop is M and the inner loop is P. Any combination whose intermediate oscillator frequency falls outside the allowed window is discarded. Of the rest, the block keeps the combination whose output lies closest to the request.

The oscillator frequency for each N is built from one quotient and remainder, `ref / N`, produced by a serial restoring divider. An accumulator adds that quotient once per M step and carries the remainder. This yields the exact truncated value of `ref * M / N` at one cycle per M, without a divide for every candidate.

When the search finishes, the block holds the chosen M, N and P, the achieved frequency and the remaining error, and raises a one-cycle done pulse. It also presents the P value in the form the synthesizer's register expects, with bit 3 forced high.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy_o and done_o are 0; found_o, m_o, n_o, p_o, freq_o and err_o are 0; p_code_o is 4'h8.
- R2: A start_i pulse is accepted only while the block is idle. busy_o reads 1 at the first clock after acceptance. A start_i during a search, including the cycle in which done_o is high, does not change the request being searched and does not begin a new search.
- R3: N runs from 2 to 14 as the outermost loop and M from 2 to 255 inside it. The oscillator value is floor(ref × M / N), exact for any ref below 2^19 kHz.
- R4: A candidate is kept for evaluation only if its oscillator value lies in [110000, 250000] kHz, both ends inclusive.
- R5: For each kept oscillator value, P runs from 0 to 4. The output is the oscillator value shifted right by P, and the error is the absolute difference between the request and that output.
- R6: The best error starts at 100000. The stored best changes only on a strictly smaller error, so of equal errors the first candidate in N, M, P order is kept.
- R7: If no candidate's error is below 100000, then found_o is 0, freq_o, m_o, n_o and p_o are 0, and err_o is 100000.
- R8: done_o is high for exactly one clock at the end of each search. The results are valid in that cycle and stay unchanged until the next done_o.
- R9: p_code_o equals p_o with bit 3 set (p_o | 4'h8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search; honoured only when idle |
| req_khz_i | input | FREQ_W | Requested output frequency, kHz |
| ref_khz_i | input | FREQ_W | Reference frequency, kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| found_o | output | 1 | A candidate beat the starting error |
| m_o | output | M_W | Chosen feedback multiplier |
| n_o | output | N_W | Chosen reference divider |
| p_o | output | P_W | Chosen post-divider shift |
| p_code_o | output | 4 | P formatted for the synthesizer register (bit 3 set) |
| freq_o | output | FREQ_W+M_W | Achieved output frequency, kHz |
| err_o | output | FREQ_W+M_W | Absolute error of the chosen setting, kHz |

## Verification
Two events can land on the same clock: the end-of-search done pulse, and a start pulse meant to launch the next search. The bench raises start_i in exactly the cycle where done_o is high. It then requires that busy_o is low at the next sample and that no second done follows. A second case drives a start with a different request in the middle of a running search. In both cases the finished result must match a behavioural model of the full N, M, P search for the first request only.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int unsigned N_MIN    = 2;
  localparam int unsigned N_MAX    = 14;
  localparam int unsigned M_MAX    = 255;
  localparam int unsigned P_MAX    = 4;
  localparam int unsigned VCO_LO   = 110000;
  localparam int unsigned VCO_HI   = 250000;
  localparam int unsigned ERR_INIT = 100000;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_DIV, S_STEP, S_CHECK, S_EVAL, S_LATCH, S_FIN
  } search_state_e;
endpackage

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
  parameter int unsigned DW = 19,
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [SW-1:0] rem_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] q_q;
  logic [SW-1:0] r_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [SW:0]   shl, diff;
  logic          fit;

  always_comb begin
    shl  = {r_q, q_q[DW-1]};
    fit  = shl >= {1'b0, divisor_i};
    diff = shl - {1'b0, divisor_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= dividend_i;
        r_q   <= '0;
        cnt_q <= CW'(DW);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[DW-2:0], fit};
        r_q   <= fit ? diff[SW-1:0] : shl[SW-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = q_q;
  assign rem_o  = r_q;

  assert_div_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> divisor_i != '0);
  assert_div_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> r_q < divisor_i);
endmodule

// File: rtl/pll_vco_accum.sv
module pll_vco_accum #(
  parameter int unsigned FREQ_W = 19,
  parameter int unsigned N_W    = 4,
  parameter int unsigned VCO_W  = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [FREQ_W-1:0] qd_i,
  input  logic [N_W-1:0]    rd_i,
  input  logic [N_W-1:0]    div_i,
  output logic [VCO_W-1:0]  vco_o
);
  logic [VCO_W-1:0] vco_q;
  logic [N_W-1:0]   rem_q;
  logic [N_W:0]     rsum;
  logic             carry;

  always_comb begin
    rsum  = {1'b0, rem_q} + {1'b0, rd_i};
    carry = rsum >= {1'b0, div_i};
  end

  // vco(M+1) = vco(M) + ref/N, plus one when the remainders wrap past N
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vco_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      vco_q <= VCO_W'(qd_i);
      rem_q <= rd_i;
    end else if (step_i) begin
      vco_q <= vco_q + VCO_W'(qd_i) + VCO_W'(carry);
      rem_q <= carry ? N_W'(rsum - {1'b0, div_i}) : rsum[N_W-1:0];
    end
  end

  assign vco_o = vco_q;

  assert_accum_rem_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || step_i) |=> rem_q < div_i);
endmodule

// File: rtl/pll_best_track.sv
module pll_best_track
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W = 19,
  parameter int unsigned VCO_W  = 27,
  parameter int unsigned M_W    = 8,
  parameter int unsigned N_W    = 4,
  parameter int unsigned P_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              eval_i,
  input  logic [FREQ_W-1:0] req_i,
  input  logic [VCO_W-1:0]  out_i,
  input  logic [M_W-1:0]    m_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [P_W-1:0]    p_i,
  output logic [VCO_W-1:0]  err_o,
  output logic [VCO_W-1:0]  freq_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [P_W-1:0]    p_o,
  output logic              hit_o
);
  logic [VCO_W-1:0] req_ext, err_now;
  logic             better;

  always_comb begin
    req_ext = VCO_W'(req_i);
    err_now = (out_i >= req_ext) ? out_i - req_ext : req_ext - out_i;
    better  = eval_i && (err_now < err_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= VCO_W'(ERR_INIT);
      freq_o <= '0;
      m_o    <= '0;
      n_o    <= '0;
      p_o    <= '0;
      hit_o  <= 1'b0;
    end else if (clr_i) begin
      err_o  <= VCO_W'(ERR_INIT);
      freq_o <= '0;
      m_o    <= '0;
      n_o    <= '0;
      p_o    <= '0;
      hit_o  <= 1'b0;
    end else if (better) begin
      err_o  <= err_now;
      freq_o <= out_i;
      m_o    <= m_i;
      n_o    <= n_i;
      p_o    <= p_i;
      hit_o  <= 1'b1;
    end
  end

  assert_best_monotone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> err_o <= $past(err_o));
  assert_best_capped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> err_o < VCO_W'(ERR_INIT));
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W = 19,
  parameter int unsigned M_W    = 8,
  parameter int unsigned N_W    = 4,
  parameter int unsigned P_W    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FREQ_W-1:0]     req_khz_i,
  input  logic [FREQ_W-1:0]     ref_khz_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  found_o,
  output logic [M_W-1:0]        m_o,
  output logic [N_W-1:0]        n_o,
  output logic [P_W-1:0]        p_o,
  output logic [3:0]            p_code_o,
  output logic [FREQ_W+M_W-1:0] freq_o,
  output logic [FREQ_W+M_W-1:0] err_o
);
  localparam int unsigned VCO_W = FREQ_W + M_W;

  search_state_e state_q;
  logic [FREQ_W-1:0] req_q, ref_q;
  logic [N_W-1:0]    n_q;
  logic [M_W-1:0]    m_q;
  logic [P_W-1:0]    p_q;

  logic              div_start, div_done;
  logic [FREQ_W-1:0] div_quot;
  logic [N_W-1:0]    div_rem;
  logic              acc_load, acc_step;
  logic [VCO_W-1:0]  vco;
  logic              clr, eval, in_win, last_m, last_n;
  logic [VCO_W-1:0]  cand_out;
  logic [VCO_W-1:0]  b_err, b_freq;
  logic [M_W-1:0]    b_m;
  logic [N_W-1:0]    b_n;
  logic [P_W-1:0]    b_p;
  logic              b_hit;

  always_comb begin
    clr       = (state_q == S_IDLE) && start_i;
    div_start = (state_q == S_LOAD);
    acc_load  = (state_q == S_DIV) && div_done;
    acc_step  = (state_q == S_STEP);
    eval      = (state_q == S_EVAL);
    in_win    = (vco >= VCO_W'(VCO_LO)) && (vco <= VCO_W'(VCO_HI));
    cand_out  = vco >> p_q;
    last_m    = (m_q == M_W'(M_MAX));
    last_n    = (n_q == N_W'(N_MAX));
  end

  pll_div_restoring #(.DW(FREQ_W), .SW(N_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i(ref_q), .divisor_i(n_q),
    .done_o(div_done), .quot_o(div_quot), .rem_o(div_rem)
  );

  pll_vco_accum #(.FREQ_W(FREQ_W), .N_W(N_W), .VCO_W(VCO_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc_load), .step_i(acc_step),
    .qd_i(div_quot), .rd_i(div_rem), .div_i(n_q), .vco_o(vco)
  );

  pll_best_track #(.FREQ_W(FREQ_W), .VCO_W(VCO_W), .M_W(M_W), .N_W(N_W), .P_W(P_W)) u_best (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .eval_i(eval),
    .req_i(req_q), .out_i(cand_out), .m_i(m_q), .n_i(n_q), .p_i(p_q),
    .err_o(b_err), .freq_o(b_freq), .m_o(b_m), .n_o(b_n), .p_o(b_p), .hit_o(b_hit)
  );

  // next M, next N, or wrap up
  function automatic search_state_e advance(input logic lm, input logic ln);
    if (!lm)     return S_STEP;
    else if (ln) return S_LATCH;
    else         return S_LOAD;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      req_q   <= '0;
      ref_q   <= '0;
      n_q     <= '0;
      m_q     <= '0;
      p_q     <= '0;
      found_o <= 1'b0;
      m_o     <= '0;
      n_o     <= '0;
      p_o     <= '0;
      freq_o  <= '0;
      err_o   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          req_q   <= req_khz_i;
          ref_q   <= ref_khz_i;
          n_q     <= N_W'(N_MIN);
          state_q <= S_LOAD;
        end
        S_LOAD: state_q <= S_DIV;
        S_DIV: if (div_done) begin
          m_q     <= M_W'(1);
          state_q <= S_STEP;
        end
        S_STEP: begin
          m_q     <= m_q + M_W'(1);
          state_q <= S_CHECK;
        end
        S_CHECK: if (in_win) begin
          p_q     <= '0;
          state_q <= S_EVAL;
        end else begin
          state_q <= advance(last_m, last_n);
          if (last_m && !last_n) n_q <= n_q + N_W'(1);
        end
        S_EVAL: if (p_q == P_W'(P_MAX)) begin
          state_q <= advance(last_m, last_n);
          if (last_m && !last_n) n_q <= n_q + N_W'(1);
        end else begin
          p_q <= p_q + P_W'(1);
        end
        S_LATCH: begin
          found_o <= b_hit;
          m_o     <= b_m;
          n_o     <= b_n;
          p_o     <= b_p;
          freq_o  <= b_freq;
          err_o   <= b_err;
          state_q <= S_FIN;
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_FIN);
  assign p_code_o = 4'h8 | 4'(p_o);

  assert_div_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> (VCO_W'(div_quot) * VCO_W'(n_q) + VCO_W'(div_rem)) == VCO_W'(ref_q));
  assert_n_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |-> (n_q >= N_W'(N_MIN)) && (n_q <= N_W'(N_MAX)));
  assert_eval_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval |-> (vco >= VCO_W'(VCO_LO)) && (vco <= VCO_W'(VCO_HI)));
  assert_p_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval |-> p_q <= P_W'(P_MAX));
  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(req_q) && $stable(ref_q));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_miss_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (freq_o == '0) && (m_o == '0) && (err_o == VCO_W'(ERR_INIT)));
endmodule

// File: tb/pll_coef_search_bench.sv
`timescale 1ns/1ps
module pll_coef_search_bench;
  localparam int FREQ_W = 19;
  localparam int VCO_W  = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FREQ_W-1:0] req = '0, rf = '0;
  logic busy, done, found;
  logic [7:0] m;
  logic [3:0] n;
  logic [2:0] p;
  logic [3:0] pcode;
  logic [VCO_W-1:0] freq, err;

  int checks = 0, errors = 0;
  bit finished = 0, mon_en = 0, prev_done = 0;
  int h_m = 0, h_n = 0, h_p = 0, h_freq = 0, h_err = 0, h_found = 0;

  always #2 clk = ~clk;

  pll_coef_search u_pll_coef_search (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_khz_i(req), .ref_khz_i(rf),
    .busy_o(busy), .done_o(done), .found_o(found), .m_o(m), .n_o(n), .p_o(p),
    .p_code_o(pcode), .freq_o(freq), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int rq, input int rfk, output int em, output int en,
                       output int ep, output int efreq, output int eerr, output int efound);
    int best = 100000;
    em = 0; en = 0; ep = 0; efreq = 0; efound = 0;
    for (int nn = 2; nn <= 14; nn++)
      for (int mm = 2; mm <= 255; mm++) begin
        int f = (rfk * mm) / nn;
        if (f < 110000 || f > 250000) continue;
        for (int pp = 0; pp <= 4; pp++) begin
          int c = f >>> pp;
          int e = (rq > c) ? rq - c : c - rq;
          if (e < best) begin
            best = e; em = mm; en = nn; ep = pp; efreq = c; efound = 1;
          end
        end
      end
    eerr = best;
  endtask

  // every clock: single-cycle done and outputs held between dones (R8)
  always @(negedge clk) begin
    if (mon_en) begin
      if (done && prev_done) chk(0, "R8 done wider than one cycle", 1, 0);
      if (done) begin
        h_m = m; h_n = n; h_p = p; h_freq = freq; h_err = err; h_found = found;
      end else if (m != h_m || n != h_n || p != h_p || freq != h_freq ||
                   err != h_err || found != h_found)
        chk(0, "R8 results changed outside done", int'(freq), h_freq);
      prev_done = done;
    end
  end

  task automatic expect_result(input int rq, input int rfk, input string tag);
    int em, en, ep, ef, ee, efd;
    model(rq, rfk, em, en, ep, ef, ee, efd);
    chk(found == efd, {tag, " R6 found"}, found, efd);
    chk(m == em,  {tag, " R3 M"}, m, em);
    chk(n == en,  {tag, " R3 N"}, n, en);
    chk(p == ep,  {tag, " R5 P"}, p, ep);
    chk(freq == ef, {tag, " R4 freq"}, freq, ef);
    chk(err == ee,  {tag, " R5 err"}, err, ee);
    chk(pcode == (ep | 8), {tag, " R9 p_code"}, pcode, ep | 8);
  endtask

  task automatic launch(input int rq, input int rfk);
    start = 1'b1; req = FREQ_W'(rq); rf = FREQ_W'(rfk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic search(input int rq, input int rfk, input string tag);
    launch(rq, rfk);
    wait_done();
    expect_result(rq, rfk, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle at reset", busy, 0);
    chk(found == 0 && m == 0 && n == 0 && p == 0, "R1 coefficients at reset", m, 0);
    chk(freq == 0 && err == 0, "R1 freq/err at reset", freq, 0);
    chk(pcode == 4'h8, "R1 p_code at reset", pcode, 8);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;

    search(25175, 14318, "typical");
    search(65000, 14318, "mid");
    search(135000, 27000, "high");
    search(1000, 14318, "low request");
    // no candidate reachable: R7
    search(400000, 14318, "unreachable R7");
    chk(found == 0 && freq == 0 && err == 100000, "R7 miss report", err, 100000);

    // start mid-search with another request: ignored (R2)
    launch(108000, 14318);
    repeat (300) @(negedge clk);
    start = 1'b1; req = FREQ_W'(31500); rf = FREQ_W'(20000);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    expect_result(108000, 14318, "start while busy R2");
    // start in the done cycle: ignored (R2), no new search
    start = 1'b1; req = FREQ_W'(50000);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0, "R2 start during done ignored", busy, 0);
    chk(done == 0, "R8 done dropped", done, 0);
    repeat (20) @(negedge clk);
    chk(busy == 0, "R2 still idle", busy, 0);

    search(50350, 16000, "second ref");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule